// File: doc/BRIEF.md
# Pipelined Wrap-Around Multiply-Accumulate Unit

This block computes a running dot product for quantised neural-network inference. Each cycle it can take one activation and one weight. It multiplies them and adds the product into a two's-complement accumulator. The accumulator is narrow on purpose. When a sum goes past the largest value, it wraps to the smallest one, and it does not saturate. A network trained to tolerate modular sums can then run with an accumulator of 8 bits or so instead of 32.

The unit has three register stages:

1. Operand capture.
2. A product register. It separates the multiplier path from the adder path.
3. The accumulator.

The product register is `min(ACT_W + WGT_W, ACC_W)` bits wide. With 8x8 operands this gives 16 bits for a 32-bit accumulator and 8 bits for an 8-bit accumulator. With 3x1 operands it gives 4 bits. A truncated product keeps its low bits. A narrower product is sign-extended before the add.

The operand stream uses valid/ready. `in_ready` is high whenever reset is released, so the unit never applies back-pressure. A beat transfers on each rising edge where `in_valid` and `in_ready` are both high. `in_clr` is a plain control pin. It is sampled every cycle and travels down the pipeline beside the beat it arrived with. Because of this, a clear is ordered exactly within the operand stream.

Top module: `lowres_mac`

## Requirements
- R1: After reset, `acc_value` is 0 and `acc_upd` is 0.
- R2: While `rst_n` is high, `in_ready` is 1, and a beat is accepted on every cycle with no gaps between cycles.
- R3: A beat or clear sampled at rising edge k is reflected in `acc_value` after edge k+2, and `acc_upd` is 1 for the cycle after that edge.
- R4: A valid beat without clear adds its product to the accumulator modulo 2^ACC_W. Going past the largest positive value wraps to negative values, and going below the most negative value wraps to positive values.
- R5: When ACC_W < ACT_W+WGT_W, only the low ACC_W bits of the product are added. For example, 127x127 adds 0x01 to an 8-bit accumulator.
- R6: When ACC_W > ACT_W+WGT_W, the product is sign-extended into the accumulator. For example, (-1)x5 loads 0xFFFFFFFB into a 32-bit accumulator.
- R7: A clear sampled together with a valid beat loads that beat's product and discards the old sum.
- R8: A clear sampled without a valid beat sets the accumulator to 0 at the R3 latency.
- R9: Cycles with `in_valid` = 0 and `in_clr` = 0 leave `acc_value` unchanged and keep `acc_upd` at 0, whatever is on the operand pins.
- R10: The weight is always signed two's complement. With ACT_SIGNED = 0 the activation is unsigned. For example, a 3-bit activation of 6 times a 1-bit weight of 1 (value -1) gives -6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair valid |
| in_ready | output | 1 | Operand pair accepted; high out of reset |
| in_act | input | ACT_W | Activation operand |
| in_wgt | input | WGT_W | Weight operand (signed) |
| in_clr | input | 1 | Clear, ordered with the operand stream |
| acc_value | output | ACC_W | Accumulator value |
| acc_upd | output | 1 | Accumulator was written at the last edge |

## Verification
The bench drives one operand stream into three width configurations at once: 8x8 into 32 bits, 8x8 into 8 bits, and 3x1 into 8 bits with an unsigned activation. It compares each against a modular reference. The corner cases it targets are listed below, with the error each one would expose:

- **Wrap in both directions on the 8-bit accumulator.** A saturating adder would stick at 127 or -128.
- **Truncation of 127x127 to 0x01.** Taking the wrong product slice would give 0x3F or another value.
- **Sign extension of a small negative product into 32 bits.** Zero-extension would leave 0x0000FFFB.
- **A 3-bit activation whose top bit is set.** Treating it as signed would flip the product's sign.
- **Cycle-exact latency and ordered clears.** A clear that skips the pipeline would wipe a product already in flight. A clear that takes priority over a valid beat would load 0 instead of loading the product.

// File: rtl/lrmac_pkg.sv
package lrmac_pkg;
  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/lrmac_in_stage.sv
// Stage 1: operand capture. Operands only load on a valid beat.
module lrmac_in_stage #(
  parameter int ACT_W = 8,
  parameter int WGT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             clr,
  input  logic [ACT_W-1:0] act,
  input  logic [WGT_W-1:0] wgt,
  output logic             s1_valid,
  output logic             s1_clr,
  output logic [ACT_W-1:0] s1_act,
  output logic [WGT_W-1:0] s1_wgt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_clr   <= 1'b0;
      s1_act   <= '0;
      s1_wgt   <= '0;
    end else begin
      s1_valid <= beat;
      s1_clr   <= clr;
      if (beat) begin
        s1_act <= act;
        s1_wgt <= wgt;
      end
    end
  end

  // Idle cycles must not disturb captured operands (R9).
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(s1_act) && $stable(s1_wgt));
endmodule

// File: rtl/lrmac_mult_stage.sv
// Stage 2: multiply and register the product, truncated to PROD_W bits.
module lrmac_mult_stage #(
  parameter int ACT_W      = 8,
  parameter int WGT_W      = 8,
  parameter int PROD_W     = 16,
  parameter bit ACT_SIGNED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic              s1_clr,
  input  logic [ACT_W-1:0]  s1_act,
  input  logic [WGT_W-1:0]  s1_wgt,
  output logic              s2_valid,
  output logic              s2_clr,
  output logic [PROD_W-1:0] s2_prod
);
  localparam int FULL_W = ACT_W + WGT_W;

  logic [FULL_W-1:0] act_ext;
  logic [FULL_W-1:0] wgt_ext;
  logic [FULL_W-1:0] full_prod;

  generate
    if (ACT_SIGNED) begin : g_act_signed
      assign act_ext = {{WGT_W{s1_act[ACT_W-1]}}, s1_act};
    end else begin : g_act_unsigned
      assign act_ext = {{WGT_W{1'b0}}, s1_act};
    end
  endgenerate

  assign wgt_ext   = {{ACT_W{s1_wgt[WGT_W-1]}}, s1_wgt};
  assign full_prod = act_ext * wgt_ext;   // low FULL_W bits are exact

  generate
    if (PROD_W < FULL_W) begin : g_trunc
      logic unused_hi;
      assign unused_hi = ^full_prod[FULL_W-1:PROD_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_clr   <= 1'b0;
      s2_prod  <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_clr   <= s1_clr;
      if (s1_valid) s2_prod <= full_prod[PROD_W-1:0];
    end
  end

  assert_prod_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(s2_prod));
endmodule

// File: rtl/lrmac_acc_stage.sv
// Stage 3: wrap-around accumulator with stream-ordered clear.
module lrmac_acc_stage #(
  parameter int PROD_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s2_valid,
  input  logic              s2_clr,
  input  logic [PROD_W-1:0] s2_prod,
  output logic [ACC_W-1:0]  acc_q,
  output logic              upd_q
);
  logic [ACC_W-1:0] prod_ext;

  generate
    if (PROD_W < ACC_W) begin : g_sext
      assign prod_ext = {{(ACC_W-PROD_W){s2_prod[PROD_W-1]}}, s2_prod};
    end else begin : g_same
      assign prod_ext = s2_prod;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= s2_valid | s2_clr;
      if (s2_clr)        acc_q <= s2_valid ? prod_ext : '0;
      else if (s2_valid) acc_q <= acc_q + prod_ext;   // modular wrap
    end
  end

  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid && !s2_clr |=> $stable(acc_q) && !upd_q);
  assert_clr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s2_clr && !s2_valid |=> acc_q == '0);
  assert_clr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s2_clr && s2_valid |=> acc_q == $past(prod_ext));
  assert_change_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> upd_q);
endmodule

// File: rtl/lowres_mac.sv
module lowres_mac
  import lrmac_pkg::*;
#(
  parameter int ACT_W      = 8,
  parameter int WGT_W      = 8,
  parameter int ACC_W      = 32,
  parameter bit ACT_SIGNED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ACT_W-1:0] in_act,
  input  logic [WGT_W-1:0] in_wgt,
  input  logic             in_clr,
  output logic [ACC_W-1:0] acc_value,
  output logic             acc_upd
);
  localparam int FULL_W = ACT_W + WGT_W;
  localparam int PROD_W = min_int(FULL_W, ACC_W);

  logic              beat;
  logic              s1_valid, s1_clr, s2_valid, s2_clr;
  logic [ACT_W-1:0]  s1_act;
  logic [WGT_W-1:0]  s1_wgt;
  logic [PROD_W-1:0] s2_prod;

  assign in_ready = rst_n;   // never back-pressures
  assign beat     = in_valid & in_ready;

  lrmac_in_stage #(.ACT_W(ACT_W), .WGT_W(WGT_W)) u_in (
    .clk(clk), .rst_n(rst_n), .beat(beat), .clr(in_clr),
    .act(in_act), .wgt(in_wgt),
    .s1_valid(s1_valid), .s1_clr(s1_clr), .s1_act(s1_act), .s1_wgt(s1_wgt));

  lrmac_mult_stage #(.ACT_W(ACT_W), .WGT_W(WGT_W), .PROD_W(PROD_W),
                     .ACT_SIGNED(ACT_SIGNED)) u_mul (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_clr(s1_clr),
    .s1_act(s1_act), .s1_wgt(s1_wgt),
    .s2_valid(s2_valid), .s2_clr(s2_clr), .s2_prod(s2_prod));

  lrmac_acc_stage #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_clr(s2_clr),
    .s2_prod(s2_prod), .acc_q(acc_value), .upd_q(acc_upd));

  // Edges since reset release, saturating, so $past(...,3) sees only post-reset inputs.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)               age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    age_q == 2'd3 |-> acc_upd == $past(beat || in_clr, 3));
  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/lowres_mac_tb.sv
module lowres_mac_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, vin, cin;
  logic [7:0] a_in, w_in;
  logic [31:0] acc0;
  logic [7:0]  acc1, acc2;
  logic rdy0, rdy1, rdy2, upd0, upd1, upd2;
  logic [31:0] exp0;
  logic [7:0]  exp1, exp2;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lowres_mac #(.ACT_W(8), .WGT_W(8), .ACC_W(32), .ACT_SIGNED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_ready(rdy0), .in_act(a_in),
    .in_wgt(w_in), .in_clr(cin), .acc_value(acc0), .acc_upd(upd0));
  lowres_mac #(.ACT_W(8), .WGT_W(8), .ACC_W(8), .ACT_SIGNED(1'b1)) u_dut_w8 (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_ready(rdy1), .in_act(a_in),
    .in_wgt(w_in), .in_clr(cin), .acc_value(acc1), .acc_upd(upd1));
  lowres_mac #(.ACT_W(3), .WGT_W(1), .ACC_W(8), .ACT_SIGNED(1'b0)) u_dut_t (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_ready(rdy2), .in_act(a_in[2:0]),
    .in_wgt(w_in[0:0]), .in_clr(cin), .acc_value(acc2), .acc_upd(upd2));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Drive one cycle and update the modular reference model.
  task automatic beat(input logic [7:0] a, input logic [7:0] w, input logic v, input logic c);
    logic signed [15:0] p0;
    logic [7:0] p2;
    a_in = a; w_in = w; vin = v; cin = c;
    p0 = $signed(a) * $signed(w);
    p2 = w[0] ? (8'd0 - {5'd0, a[2:0]}) : 8'd0;
    if (c) begin
      exp0 = v ? {{16{p0[15]}}, p0} : 32'd0;
      exp1 = v ? p0[7:0] : 8'd0;
      exp2 = v ? p2 : 8'd0;
    end else if (v) begin
      exp0 = exp0 + {{16{p0[15]}}, p0};
      exp1 = exp1 + p0[7:0];
      exp2 = exp2 + p2;
    end
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(8'hA5 ^ 8'(i), 8'h5A + 8'(i), 1'b0, 1'b0);
  endtask

  task automatic check_all(input string req);
    chk(acc0 == exp0, {req, " cfg32"}, acc0, exp0);
    chk(acc1 == exp1, {req, " cfg8"},  {24'd0, acc1}, {24'd0, exp1});
    chk(acc2 == exp2, {req, " cfg3x1"}, {24'd0, acc2}, {24'd0, exp2});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; vin = 0; cin = 0; a_in = 0; w_in = 0;
    exp0 = 0; exp1 = 0; exp2 = 0;
    repeat (3) step();
    check_all("R1 reset value");
    chk(!(upd0 | upd1 | upd2), "R1 upd low", {29'd0, upd0, upd1, upd2}, 0);
    rst_n = 1'b1;
    #1;
    chk(rdy0 & rdy1 & rdy2, "R2 ready", {29'd0, rdy0, rdy1, rdy2}, 32'h7);
  endtask

  task automatic t_latency();
    beat(8'd0, 8'd0, 1'b0, 1'b1); idle(3);
    beat(8'd3, 8'd4, 1'b1, 1'b0);           // past E1
    vin = 0; cin = 0; step();               // past E2
    chk(acc0 == 0 && !upd0, "R3 not yet", acc0, 0);
    step();                                 // past E3
    chk(acc0 == 12 && upd0, "R3 arrives", acc0, 12);
    step();
    chk(!upd0, "R3 upd one cycle", {31'd0, upd0}, 0);
    idle(2);
    check_all("R3 flush");
  endtask

  task automatic t_throughput();
    int sum = 0;
    beat(8'd0, 8'd0, 1'b1, 1'b1); idle(3);
    for (int j = 0; j < 8; j++) begin
      beat(8'(j + 1), 8'd3, 1'b1, 1'b0);
      if (j >= 2) begin
        sum += 3 * (j - 1);
        chk(acc0 == 32'(sum) && upd0, "R2 one beat per cycle", acc0, 32'(sum));
      end
    end
    idle(3);
    check_all("R2 back-to-back");
  endtask

  task automatic t_stream();
    beat(8'd0, 8'd0, 1'b0, 1'b1);
    for (int j = 0; j < 20; j++)
      beat(8'(j * 37 + 5), 8'(13 * j - 50), 1'(j % 3 != 1), 1'b0);
    idle(3);
    check_all("R4 mixed stream");
  endtask

  task automatic t_wrap();
    beat(8'd10, 8'd10, 1'b1, 1'b1);
    beat(8'd5, 8'd10, 1'b1, 1'b0);
    idle(3);
    chk(acc1 == 8'h96, "R4 wrap up", {24'd0, acc1}, 32'h96);
    check_all("R4 wrap up");
    beat(8'hF6, 8'd10, 1'b1, 1'b1);         // -100
    beat(8'hCE, 8'd1, 1'b1, 1'b0);          // -50
    idle(3);
    chk(acc1 == 8'h6A, "R4 wrap down", {24'd0, acc1}, 32'h6A);
    check_all("R4 wrap down");
  endtask

  task automatic t_trunc();
    beat(8'd127, 8'd127, 1'b1, 1'b1);
    idle(3);
    chk(acc1 == 8'h01, "R5 truncate", {24'd0, acc1}, 1);
    chk(acc0 == 32'd16129, "R5 full in 32", acc0, 16129);
    beat(8'h80, 8'h80, 1'b1, 1'b0);
    idle(3);
    chk(acc1 == 8'h01, "R5 low byte zero", {24'd0, acc1}, 1);
    check_all("R5 truncate");
  endtask

  task automatic t_sext();
    beat(8'hFF, 8'd5, 1'b1, 1'b1);
    idle(3);
    chk(acc0 == 32'hFFFF_FFFB, "R6 sign extend", acc0, 32'hFFFF_FFFB);
    chk(acc2 == 8'hF9, "R6 sign extend 4b", {24'd0, acc2}, 32'hF9);
    check_all("R6 sign extend");
  endtask

  task automatic t_clear_valid();
    beat(8'd9, 8'd9, 1'b1, 1'b0);
    beat(8'd6, 8'd7, 1'b1, 1'b1);
    idle(3);
    chk(acc0 == 32'd42, "R7 clear loads", acc0, 42);
    check_all("R7 clear loads");
  endtask

  task automatic t_clear_only();
    beat(8'd20, 8'd3, 1'b1, 1'b0);
    beat(8'd77, 8'd55, 1'b0, 1'b1);
    idle(3);
    chk(acc0 == 0 && acc1 == 0 && acc2 == 0, "R8 clear zero", acc0, 0);
    check_all("R8 clear zero");
  endtask

  task automatic t_idle();
    logic [31:0] hold;
    beat(8'd11, 8'd13, 1'b1, 1'b1);
    idle(3);
    hold = acc0;
    for (int i = 0; i < 5; i++) begin
      beat(8'(i * 51 + 1), 8'(200 - i * 9), 1'b0, 1'b0);
      chk(acc0 == hold && !upd0 && !upd1 && !upd2, "R9 idle ignored", acc0, hold);
    end
    check_all("R9 idle ignored");
  endtask

  task automatic t_unsigned();
    beat(8'h06, 8'h01, 1'b1, 1'b1);
    idle(3);
    chk(acc2 == 8'hFA, "R10 unsigned act", {24'd0, acc2}, 32'hFA);
    beat(8'h05, 8'h00, 1'b1, 1'b0);
    idle(3);
    chk(acc2 == 8'hFA, "R10 zero weight", {24'd0, acc2}, 32'hFA);
    check_all("R10 unsigned act");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_latency();
    t_throughput();
    t_stream();
    t_wrap();
    t_trunc();
    t_sext();
    t_clear_valid();
    t_clear_only();
    t_idle();
    t_unsigned();
    finish_run();
  end
endmodule